// File: doc/BRIEF.md
# Guarded Configuration Launcher

This block decides when a chain of downstream FPGAs may be told to reload their configuration, and then paces that reload. It watches an active-low global request line. A reload is accepted only when that line has been held low for a sustained qualification window and the configure-mode bit is set. Configure mode and transmit mode exclude each other. Short glitches on the request line are thrown away. They leave nothing behind that could add up with a later glitch.

Once a request is accepted, the block pulls an active-low program output low for a fixed number of cycles. It then runs a slow configuration clock for a fixed number of periods. That clock comes from a divider chain with four taps, each at double the period of the one below (250 ns, 500 ns, 1 us and 2 us at the default rates), and the slowest tap is used. Alongside the clock the block raises a one-cycle enable that steps the configuration ROM, and a busy output that can light an LED while the clock runs. Only one local source and one ROM exist, so no source selection is needed. After a load, the request line must return high before another request can be qualified.

Top module: `cfg_launch_guard`

## Requirements
- R1: When `cfg_enable` is 1, a low level on `glob_cfg_n` lasting at least QUAL_CYCLES consecutive clock cycles starts exactly one configuration cycle. With the default 40 MHz clock and QUAL_CYCLES of 81, this window is just over 2 us.
- R2: A low run shorter than QUAL_CYCLES never starts a cycle. A single high cycle erases all progress, so two short runs separated by one high cycle do not start a cycle either.
- R3: While `cfg_enable` is 0, `prog_n` stays 1 whatever `glob_cfg_n` does. If `cfg_enable` is set while an already-qualified low level is still present, a cycle starts.
- R4: `prog_n` is 0 for exactly PROG_CYCLES clock cycles. `busy_led` rises in the same cycle that `prog_n` returns to 1, and the two are never active together.
- R5: `cfg_clk` has a period of PRE_CYCLES·2^TAP_COUNT clock cycles at 50% duty, starting with its low half. `busy_led` stays high for exactly LOAD_CLKS such periods.
- R6: `busy_led` is 1 exactly while the configuration clock runs. `cfg_clk` is 0 whenever `busy_led` is 0.
- R7: `rom_ce` is a single-cycle pulse in the first cycle of every high phase of `cfg_clk`. There are exactly LOAD_CLKS pulses per configuration cycle.
- R8: After a load ends, no new cycle starts while `glob_cfg_n` is still low. Once the line has returned high, a fresh qualified low starts a new cycle.
- R9: In reset and immediately after it, `prog_n` is 1 and `cfg_clk`, `rom_ce` and `busy_led` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| glob_cfg_n | input | 1 | Global configure request, active low, asynchronous |
| cfg_enable | input | 1 | Configure-mode bit (1 = configure allowed, transmit barred) |
| prog_n | output | 1 | Active-low program pulse to the downstream FPGAs |
| cfg_clk | output | 1 | Divided configuration clock |
| rom_ce | output | 1 | One-cycle configuration ROM clock enable |
| busy_led | output | 1 | High while the configuration clock runs |

## Verification
Two events can land on the same clock edge: the request line returning high, and the low-run count reaching its threshold. The bench provokes this with low pulses of exactly QUAL_CYCLES and QUAL_CYCLES−1. The first must start a cycle and the second must not, so the threshold decision wins over the clearing that happens in the same cycle. A second collision arises when the configure-mode bit is set while the qualification count is already saturated. That start is expected, and the load must then run with the correct pulse length, period count and ROM-enable count.

// File: rtl/cfg_launch_pkg.sv
package cfg_launch_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROG  = 2'd1,
        ST_LOAD  = 2'd2,
        ST_REARM = 2'd3
    } seq_state_e;

    function automatic int unsigned cnt_width(input int unsigned max_val);
        int unsigned w;
        w = $clog2(max_val + 1);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/cfg_req_qualifier.sv
module cfg_req_qualifier
    import cfg_launch_pkg::*;
#(
    parameter int unsigned QUAL_CYCLES = 81
) (
    input  logic clk,
    input  logic rst,
    input  logic req_n_async,
    output logic line_high,
    output logic qual_ok
);
    localparam int unsigned CW = cnt_width(QUAL_CYCLES);

    logic [1:0]    sync_q;
    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
        end else begin
            sync_q <= {sync_q[0], req_n_async};
        end
    end

    assign line_high = sync_q[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
        end else if (line_high) begin
            low_cnt <= '0;
        end else if (low_cnt != CW'(QUAL_CYCLES)) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign qual_ok = (low_cnt == CW'(QUAL_CYCLES));

    AST_QUAL_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(qual_ok) |-> $past(!line_high)); // R1

    AST_HIGH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        line_high |=> !qual_ok); // R2

endmodule

// File: rtl/cfg_clk_divider.sv
module cfg_clk_divider
    import cfg_launch_pkg::*;
#(
    parameter int unsigned PRE_CYCLES = 5,
    parameter int unsigned TAP_COUNT  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic cfg_clk,
    output logic rom_ce,
    output logic period_done
);
    localparam int unsigned PW = cnt_width(PRE_CYCLES);

    logic [PW-1:0]        pre_cnt;
    logic                 tick;
    logic [TAP_COUNT-1:0] taps;
    logic [TAP_COUNT:0]   carry;
    logic                 rom_ce_q;

    assign tick = run && (pre_cnt == PW'(PRE_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_cnt <= '0;
        end else if (tick) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    assign carry[0] = tick;

    for (genvar k = 0; k < TAP_COUNT; k++) begin : g_tap
        assign carry[k+1] = carry[k] && taps[k];
        always_ff @(posedge clk) begin
            if (rst || !run) begin
                taps[k] <= 1'b0;
            end else if (carry[k]) begin
                taps[k] <= ~taps[k];
            end
        end
    end

    assign cfg_clk     = taps[TAP_COUNT-1];
    assign period_done = carry[TAP_COUNT];

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            rom_ce_q <= 1'b0;
        end else begin
            rom_ce_q <= carry[TAP_COUNT-1] && !taps[TAP_COUNT-1];
        end
    end

    assign rom_ce = rom_ce_q;

    AST_ROMCE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        rom_ce |-> (cfg_clk && !$past(cfg_clk))); // R7

    AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
        !$past(run) |-> !cfg_clk); // R6

endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
    import cfg_launch_pkg::*;
#(
    parameter int unsigned PROG_CYCLES = 13,
    parameter int unsigned LOAD_CLKS   = 97500
) (
    input  logic clk,
    input  logic rst,
    input  logic qual_ok,
    input  logic line_high,
    input  logic cfg_en,
    input  logic period_done,
    output logic prog_n,
    output logic busy
);
    localparam int unsigned PCW = cnt_width(PROG_CYCLES);
    localparam int unsigned LCW = cnt_width(LOAD_CLKS);

    seq_state_e     state;
    logic [PCW-1:0] prog_cnt;
    logic [LCW-1:0] load_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            prog_cnt <= '0;
            load_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    prog_cnt <= '0;
                    load_cnt <= '0;
                    if (qual_ok && cfg_en) begin
                        state <= ST_PROG;
                    end
                end
                ST_PROG: begin
                    if (prog_cnt == PCW'(PROG_CYCLES - 1)) begin
                        state <= ST_LOAD;
                    end else begin
                        prog_cnt <= prog_cnt + 1'b1;
                    end
                end
                ST_LOAD: begin
                    if (period_done) begin
                        if (load_cnt == LCW'(LOAD_CLKS - 1)) begin
                            state <= ST_REARM;
                        end else begin
                            load_cnt <= load_cnt + 1'b1;
                        end
                    end
                end
                ST_REARM: begin
                    if (line_high) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign prog_n = (state != ST_PROG);
    assign busy   = (state == ST_LOAD);

    AST_PROG_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $fell(prog_n) |-> $past(cfg_en)); // R3

    AST_PROG_NEEDS_QUAL: assert property (@(posedge clk) disable iff (rst)
        $fell(prog_n) |-> $past(qual_ok)); // R1

    AST_BUSY_AFTER_PROG: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $rose(prog_n)); // R4

    AST_NO_RESTART_LOW: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REARM && !line_high) |=> prog_n); // R8

endmodule

// File: rtl/cfg_launch_guard.sv
module cfg_launch_guard
    import cfg_launch_pkg::*;
#(
    parameter int unsigned QUAL_CYCLES = 81,
    parameter int unsigned PROG_CYCLES = 13,
    parameter int unsigned PRE_CYCLES  = 5,
    parameter int unsigned TAP_COUNT   = 4,
    parameter int unsigned LOAD_CLKS   = 97500
) (
    input  logic clk,
    input  logic rst,
    input  logic glob_cfg_n,
    input  logic cfg_enable,
    output logic prog_n,
    output logic cfg_clk,
    output logic rom_ce,
    output logic busy_led
);
    logic line_high;
    logic qual_ok;
    logic period_done;
    logic busy;

    cfg_req_qualifier #(
        .QUAL_CYCLES(QUAL_CYCLES)
    ) u_qual (
        .clk        (clk),
        .rst        (rst),
        .req_n_async(glob_cfg_n),
        .line_high  (line_high),
        .qual_ok    (qual_ok)
    );

    cfg_seq_ctrl #(
        .PROG_CYCLES(PROG_CYCLES),
        .LOAD_CLKS  (LOAD_CLKS)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .qual_ok    (qual_ok),
        .line_high  (line_high),
        .cfg_en     (cfg_enable),
        .period_done(period_done),
        .prog_n     (prog_n),
        .busy       (busy)
    );

    cfg_clk_divider #(
        .PRE_CYCLES(PRE_CYCLES),
        .TAP_COUNT (TAP_COUNT)
    ) u_div (
        .clk        (clk),
        .rst        (rst),
        .run        (busy),
        .cfg_clk    (cfg_clk),
        .rom_ce     (rom_ce),
        .period_done(period_done)
    );

    assign busy_led = busy;

    AST_CLK_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        cfg_clk |-> busy_led); // R6

    AST_PROG_BUSY_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!prog_n && busy_led)); // R4

endmodule

// File: tb/cfg_launch_guard_tb.sv
module cfg_launch_guard_tb;
    localparam int Q    = 20;
    localparam int PROG = 6;
    localparam int PRE  = 2;
    localparam int TAPS = 4;
    localparam int LOAD = 5;
    localparam int PERIOD = PRE * (1 << TAPS);
    localparam int BUSY_LEN = LOAD * PERIOD;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic glob_cfg_n = 1'b1;
    logic cfg_enable = 1'b0;
    logic prog_n, cfg_clk, rom_ce, busy_led;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    int starts = 0;
    int prog_run = 0, busy_run = 0, rise_run = 0, romce_run = 0;
    int last_prog = 0, last_busy = 0, last_rise = 0, last_romce = 0;
    int v_r4 = 0, v_r6 = 0, v_r7 = 0;
    logic p_prog = 1'b1, p_busy = 1'b0, p_cfg = 1'b0;

    always #2 clk = ~clk;

    cfg_launch_guard #(
        .QUAL_CYCLES(Q), .PROG_CYCLES(PROG), .PRE_CYCLES(PRE),
        .TAP_COUNT(TAPS), .LOAD_CLKS(LOAD)
    ) u_dut (
        .clk(clk), .rst(rst), .glob_cfg_n(glob_cfg_n), .cfg_enable(cfg_enable),
        .prog_n(prog_n), .cfg_clk(cfg_clk), .rom_ce(rom_ce), .busy_led(busy_led)
    );

    function automatic int exp_starts(input int low_len, input bit en);
        return (en && low_len >= Q) ? 1 : 0;
    endfunction

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (!prog_n && p_prog) starts++;
            if (!prog_n) prog_run++;
            if (prog_n && !p_prog) begin last_prog = prog_run; prog_run = 0; end
            if (busy_led && !p_busy) begin
                if (!(prog_n && !p_prog)) v_r4++;
                busy_run = 0; rise_run = 0; romce_run = 0;
            end
            if (busy_led) busy_run++;
            if (cfg_clk && !p_cfg) rise_run++;
            if (rom_ce) romce_run++;
            if (rom_ce && !(cfg_clk && !p_cfg)) v_r7++;
            if (cfg_clk && !busy_led) v_r6++;
            if (!prog_n && busy_led) v_r4++;
            if (!busy_led && p_busy) begin
                last_busy = busy_run; last_rise = rise_run; last_romce = romce_run;
            end
            p_prog = prog_n; p_busy = busy_led; p_cfg = cfg_clk;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            summary();
        end
    end

    task automatic check_load(input string rq);
        check(last_prog == PROG, "R4 prog_n low length", last_prog, PROG);
        check(last_busy == BUSY_LEN, "R5 busy length", last_busy, BUSY_LEN);
        check(last_rise == LOAD, "R5 cfg_clk rises", last_rise, LOAD);
        check(last_romce == LOAD, "R7 rom_ce pulses", last_romce, LOAD);
    endtask

    task automatic run_case(input int low_len, input bit en, input string rq);
        int s0;
        s0 = starts;
        cfg_enable = en;
        glob_cfg_n = 1'b0;
        repeat (low_len) @(negedge clk);
        glob_cfg_n = 1'b1;
        repeat (BUSY_LEN + PROG + 30) @(negedge clk);
        check(starts - s0 == exp_starts(low_len, en), rq, starts - s0, exp_starts(low_len, en));
        if (exp_starts(low_len, en) == 1) check_load(rq);
    endtask

    initial begin
        int s0;
        int rv;
        rv = $urandom(32'h5EED_0C0F);
        repeat (4) @(negedge clk);
        check(prog_n == 1'b1 && cfg_clk == 1'b0 && rom_ce == 1'b0 && busy_led == 1'b0,
              "R9 in reset", {prog_n, cfg_clk, rom_ce, busy_led}, 4'b1000);
        rst = 1'b0;
        @(negedge clk);
        check(prog_n == 1'b1 && cfg_clk == 1'b0 && rom_ce == 1'b0 && busy_led == 1'b0,
              "R9 after reset", {prog_n, cfg_clk, rom_ce, busy_led}, 4'b1000);

        run_case(Q, 1'b1, "R1 exact threshold");
        run_case(Q - 1, 1'b1, "R2 one short");
        run_case(Q + 7, 1'b1, "R1 long low");
        run_case(Q + 7, 1'b0, "R3 enable off");

        // R2: two short runs split by one high cycle must not add up
        s0 = starts;
        cfg_enable = 1'b1;
        glob_cfg_n = 1'b0; repeat (Q - 1) @(negedge clk);
        glob_cfg_n = 1'b1; @(negedge clk);
        glob_cfg_n = 1'b0; repeat (Q - 1) @(negedge clk);
        glob_cfg_n = 1'b1; repeat (40) @(negedge clk);
        check(starts == s0, "R2 split runs", starts - s0, 0);

        // R3 late enable, then R8 held-low line after load
        s0 = starts;
        cfg_enable = 1'b0;
        glob_cfg_n = 1'b0; repeat (Q + 5) @(negedge clk);
        check(starts == s0, "R3 held off", starts - s0, 0);
        cfg_enable = 1'b1;
        repeat (BUSY_LEN + PROG + 20) @(negedge clk);
        check(starts - s0 == 1, "R3 late enable start", starts - s0, 1);
        check_load("R3 late enable");
        repeat (60) @(negedge clk);
        check(starts - s0 == 1, "R8 no restart while low", starts - s0, 1);
        glob_cfg_n = 1'b1; repeat (5) @(negedge clk);
        run_case(Q, 1'b1, "R8 restart after high");

        for (int i = 0; i < 12; i++) begin
            int len;
            bit en;
            len = Q - 6 + int'($urandom % 13);
            en  = ($urandom % 4) != 0;
            run_case(len, en, "R1 random pulse");
        end

        check(v_r4 == 0, "R4 busy/prog ordering", v_r4, 0);
        check(v_r6 == 0, "R6 cfg_clk outside busy", v_r6, 0);
        check(v_r7 == 0, "R7 rom_ce placement", v_r7, 0);
        done = 1;
        summary();
    end
endmodule